// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Occupancy Direction Latch

This block carries data words from a write clock domain to a read clock domain whose clocks have no fixed relation. It holds exactly `DEPTH` words in `DEPTH` register locations. The pointers are only `log2(DEPTH)` bits wide, so they carry no extra wrap bit, and no spare location is reserved. When the two pointers are equal, the FIFO is either completely empty or completely full. A single direction latch decides which.

The direction latch does not look at which side moved last. It compares the two most significant bits of the Gray-coded pointers, which give the quadrant each pointer is in. When the writer sits one quadrant behind the reader, occupancy is above half, and the latch is set so that the next equality means full. When the writer sits one quadrant ahead, occupancy is below half, and the latch is cleared so that the next equality means empty.

The equality and direction terms are formed directly from the live Gray pointers of both domains. They drive the asynchronous set of a short flag chain in each domain. As a result, `wr_full` rises on the write edge that fills the FIFO, and `rd_empty` rises on the read edge that drains it. Each flag falls only after `SYNC_STAGES` edges of its own clock. Read data is registered and appears one read-clock cycle after an accepted read.

Top module: `afifo_dirq`

## Requirements
- R1: After reset, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R2: Starting from empty, exactly `DEPTH` writes are accepted with `wr_full` low. `wr_full` is 1 when sampled in the same write cycle as the clock edge that stored the `DEPTH`-th word.
- R3: Words leave the read port in the order they were written, with unchanged values, for write and read clock periods of any ratio.
- R4: A write attempted while `wr_full` is 1 changes neither the write pointer nor any stored word, and `wr_full` stays 1.
- R5: A read attempted while `rd_empty` is 1 changes neither the read pointer nor `rd_data`, and `rd_empty` stays 1.
- R6: `rd_data` changes only on a `rd_clk` rising edge where `rd_en` is 1 and `rd_empty` is 0. On such an edge it takes the oldest stored word.
- R7: `rd_empty` is 1 when sampled in the same read cycle as the edge that took the last stored word.
- R8: After a write into an empty FIFO, `rd_empty` falls within `SYNC_STAGES`+1 `rd_clk` cycles. After a read from a full FIFO, `wr_full` falls within `SYNC_STAGES`+1 `wr_clk` cycles.
- R9: Full and empty are detected correctly for every one of the `DEPTH` possible pointer positions at which equality can occur.
- R10: If the reader drains the whole full FIFO within about one write-clock period, `wr_full` still falls within `SYNC_STAGES`+1 write cycles. After that, `DEPTH` further writes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write request, accepted when `wr_full` is 0 |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | FIFO holds DEPTH words (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request, accepted when `rd_empty` is 0 |
| rd_data | output | DW | Registered read word, valid one cycle after an accepted read |
| rd_empty | output | 1 | FIFO holds no word (read domain) |

## Verification
The hardest case to reach is a whole-FIFO drain that completes inside roughly one write-clock period. If that lap were missed, the write side would misjudge the final pointer equality as full and stay locked. The bench speeds the read clock to eight times the write clock and holds `rd_en` high for a burst of `DEPTH` reads. It then requires `wr_full` to clear and a further `DEPTH` writes to go through. Every equality position is also swept by advancing both pointers one step between full and empty cycles, and this sweep is repeated at three read-clock ratios.

// File: rtl/afifo_pkg.sv
`timescale 1ns / 1ps
package afifo_pkg;
   localparam int unsigned MIN_DEPTH = 4;
   localparam int unsigned MIN_SYNC  = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Top two Gray bits form a quadrant code in the order 00,01,11,10.
   // Writer one quadrant behind reader: occupancy above half.
   function automatic logic quad_writer_behind(input logic [1:0] wq, input logic [1:0] rq);
      return (wq[1] ^ rq[0]) & ~(wq[0] ^ rq[1]);
   endfunction

   // Writer one quadrant ahead of reader: occupancy below half.
   function automatic logic quad_writer_ahead(input logic [1:0] wq, input logic [1:0] rq);
      return ~(wq[1] ^ rq[0]) & (wq[0] ^ rq[1]);
   endfunction
endpackage

// File: rtl/afifo_rst_sync.sv
`timescale 1ns / 1ps
module afifo_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/afifo_ptr.sv
`timescale 1ns / 1ps
module afifo_ptr #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          hold,
   output logic          fire,
   output logic [AW-1:0] bin,
   output logic [AW-1:0] gray
);
   logic [AW-1:0] bin_nxt;

   assign fire    = req & ~hold;
   assign bin_nxt = bin + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin  <= '0;
         gray <= '0;
      end else if (fire) begin
         bin  <= bin_nxt;
         gray <= bin_nxt ^ (bin_nxt >> 1);
      end
   end
endmodule

// File: rtl/afifo_flag_sync.sv
`timescale 1ns / 1ps
module afifo_flag_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raise_n,
   output logic flag
);
   logic [STAGES-1:0] sh_q;

   // Set at once by raise_n, cleared only after STAGES local edges.
   always_ff @(posedge clk or negedge rst_n or negedge raise_n) begin
      if (!rst_n)        sh_q <= {STAGES{RST_VAL}};
      else if (!raise_n) sh_q <= '1;
      else               sh_q <= {sh_q[STAGES-2:0], 1'b0};
   end

   assign flag = sh_q[STAGES-1];
endmodule

// File: rtl/afifo_dirflag.sv
`timescale 1ns / 1ps
module afifo_dirflag
   import afifo_pkg::*;
#(
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          w_rst_n,
   input  logic [AW-1:0] w_gray,
   input  logic          rd_clk,
   input  logic          r_rst_n,
   input  logic [AW-1:0] r_gray,
   output logic          wr_full,
   output logic          rd_empty
);
   logic dir_set, dir_clr, dir_q, ptr_eq;
   logic full_raise_n, empty_raise_n;

   assign dir_set = quad_writer_behind(w_gray[AW-1 -: 2], r_gray[AW-1 -: 2]);
   assign dir_clr = quad_writer_ahead(w_gray[AW-1 -: 2], r_gray[AW-1 -: 2])
                    | ~w_rst_n | ~r_rst_n;

   // Direction latch: 1 means the next equality is full.
   always_latch begin
      if (dir_clr)      dir_q <= 1'b0;
      else if (dir_set) dir_q <= 1'b1;
   end

   assign ptr_eq        = (w_gray == r_gray);
   assign full_raise_n  = ~(ptr_eq & dir_q);
   assign empty_raise_n = ~(ptr_eq & ~dir_q);

   afifo_flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_full (
      .clk(wr_clk), .rst_n(w_rst_n), .raise_n(full_raise_n), .flag(wr_full)
   );

   afifo_flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_empty (
      .clk(rd_clk), .rst_n(r_rst_n), .raise_n(empty_raise_n), .flag(rd_empty)
   );
endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns / 1ps
module afifo_mem #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_clk,
   input  logic          r_rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] cell_q [WORDS];

   always_ff @(posedge wr_clk) begin
      if (we) cell_q[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge r_rst_n) begin
      if (!r_rst_n) rdata <= '0;
      else if (re)  rdata <= cell_q[raddr];
   end
endmodule

// File: rtl/afifo_dirq.sv
`timescale 1ns / 1ps
module afifo_dirq
   import afifo_pkg::*;
#(
   parameter int DW          = 8,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          wr_full,
   input  logic          rd_clk,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_empty
);
   localparam int AW = $clog2(DEPTH);

   initial begin
      depth_cfg_chk: assert (is_pow2(DEPTH) && DEPTH >= MIN_DEPTH)
         else $error("DEPTH must be a power of two of at least %0d", MIN_DEPTH);
      sync_cfg_chk: assert (SYNC_STAGES >= MIN_SYNC)
         else $error("SYNC_STAGES must be at least %0d", MIN_SYNC);
   end

   logic          w_rst_n, r_rst_n;
   logic          w_fire, r_fire;
   logic [AW-1:0] w_bin, w_gray, r_bin, r_gray;

   afifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
      .clk(wr_clk), .arst_n(rst_n), .srst_n(w_rst_n)
   );
   afifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
      .clk(rd_clk), .arst_n(rst_n), .srst_n(r_rst_n)
   );

   afifo_ptr #(.AW(AW)) u_wptr (
      .clk(wr_clk), .rst_n(w_rst_n), .req(wr_en), .hold(wr_full),
      .fire(w_fire), .bin(w_bin), .gray(w_gray)
   );
   afifo_ptr #(.AW(AW)) u_rptr (
      .clk(rd_clk), .rst_n(r_rst_n), .req(rd_en), .hold(rd_empty),
      .fire(r_fire), .bin(r_bin), .gray(r_gray)
   );

   afifo_dirflag #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_dir (
      .wr_clk(wr_clk), .w_rst_n(w_rst_n), .w_gray(w_gray),
      .rd_clk(rd_clk), .r_rst_n(r_rst_n), .r_gray(r_gray),
      .wr_full(wr_full), .rd_empty(rd_empty)
   );

   afifo_mem #(.DW(DW), .AW(AW)) u_mem (
      .wr_clk(wr_clk), .we(w_fire), .waddr(w_bin), .wdata(wr_data),
      .rd_clk(rd_clk), .r_rst_n(r_rst_n), .re(r_fire), .raddr(r_bin),
      .rdata(rd_data)
   );
endmodule

// File: rtl/afifo_dirq_chk.sv
`timescale 1ns / 1ps
module afifo_dirq_chk #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic          wr_clk,
   input logic          w_rst_n,
   input logic          wr_en,
   input logic          wr_full,
   input logic [AW-1:0] w_bin,
   input logic [AW-1:0] w_gray,
   input logic          rd_clk,
   input logic          r_rst_n,
   input logic          rd_en,
   input logic          rd_empty,
   input logic [AW-1:0] r_bin,
   input logic [DW-1:0] rd_data
);
   // R4
   full_write_drop_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
      (wr_en && wr_full) |=> $stable(w_bin));

   // R5
   empty_read_drop_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
      (rd_en && rd_empty) |=> ($stable(r_bin) && $stable(rd_data)));

   // R2
   wptr_advance_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
      (wr_en && !wr_full) |=> (w_bin == $past(w_bin) + 1'b1));

   // R6
   rdata_hold_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
      !(rd_en && !rd_empty) |=> $stable(rd_data));

   // R3
   wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
      $countones(w_gray ^ $past(w_gray)) <= 1);
endmodule

bind afifo_dirq afifo_dirq_chk #(.DW(DW), .AW(AW)) u_chk (
   .wr_clk(wr_clk), .w_rst_n(w_rst_n), .wr_en(wr_en), .wr_full(wr_full),
   .w_bin(w_bin), .w_gray(w_gray),
   .rd_clk(rd_clk), .r_rst_n(r_rst_n), .rd_en(rd_en), .rd_empty(rd_empty),
   .r_bin(r_bin), .rd_data(rd_data)
);

// File: tb/sim_afifo_dirq.sv
`timescale 1ns / 1ps
module sim_afifo_dirq;
   localparam int N  = 8;
   localparam int DW = 8;
   localparam int S  = 2;

   logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b1;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          wr_full, rd_empty;

   int checks = 0, errors = 0;
   int wseq = 0, rseq = 0;
   logic [DW-1:0] last_rd = '0;
   realtime rhalf = 1.5;
   bit done = 1'b0;

   afifo_dirq #(.DW(DW), .DEPTH(N), .SYNC_STAGES(S)) u0 (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
      .rd_empty(rd_empty)
   );

   always #2 wr_clk = ~wr_clk;
   initial forever #(rhalf) rd_clk = ~rd_clk;

   function automatic logic [DW-1:0] pat(input int s);
      return DW'((s * 37 + 11) % 256);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push();
      @(negedge wr_clk);
      while (wr_full) @(negedge wr_clk);
      wr_data = pat(wseq); wr_en = 1'b1; wseq++;
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   task automatic pop();
      @(negedge rd_clk);
      while (rd_empty) @(negedge rd_clk);
      chk(rd_data == last_rd, "R6 idle hold", int'(rd_data), int'(last_rd));
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      chk(rd_data == pat(rseq), "R3 order", int'(rd_data), int'(pat(rseq)));
      last_rd = rd_data; rseq++;
   endtask

   task automatic wait_full_clear(input string req);
      int n = 0;
      do begin @(negedge wr_clk); n++; end while (wr_full && n < 20);
      chk(n <= S + 1, req, n, S + 1);
   endtask

   task automatic fill_drain(input int k);
      for (int i = 0; i < N; i++) begin
         @(negedge wr_clk);
         chk(wr_full == 1'b0, "R2 room", int'(wr_full), 0);
         wr_data = pat(wseq); wr_en = 1'b1; wseq++;
         @(negedge wr_clk);
         wr_en = 1'b0;
         if (i == 0) begin
            int n = 0;
            do begin @(negedge rd_clk); n++; end while (rd_empty && n < 20);
            chk(n <= S + 1, "R8 empty release", n, S + 1);
         end
      end
      chk(wr_full == 1'b1, "R2 full at DEPTH", int'(wr_full), 1);
      // R4: write while full
      @(negedge wr_clk);
      wr_data = ~pat(wseq); wr_en = 1'b1;
      @(negedge wr_clk);
      wr_en = 1'b0;
      chk(wr_full == 1'b1, "R4 still full", int'(wr_full), 1);
      for (int i = 0; i < N; i++) begin
         pop();
         if (i == 0) wait_full_clear("R8 full release");
      end
      chk(rd_empty == 1'b1, "R7 empty on last read", int'(rd_empty), 1);
      // R5: read while empty
      @(negedge rd_clk); rd_en = 1'b1;
      @(negedge rd_clk); rd_en = 1'b0;
      chk(rd_data == last_rd, "R5 data held", int'(rd_data), int'(last_rd));
      chk(rd_empty == 1'b1, "R5 still empty", int'(rd_empty), 1);
      chk(rseq == wseq, "R9 offset round trip", rseq, wseq + 0 * k);
   endtask

   initial begin : watchdog
      #200us;
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog actual=%0d expected=%0d", rseq, wseq);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      #1 rst_n = 1'b0;
      #30 rst_n = 1'b1;
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
      // R1
      chk(rd_empty == 1'b1, "R1 empty", int'(rd_empty), 1);
      chk(wr_full == 1'b0, "R1 not full", int'(wr_full), 0);
      chk(rd_data == '0, "R1 data", int'(rd_data), 0);

      for (int r = 0; r < 3; r++) begin
         rhalf = (r == 0) ? 1.5 : (r == 1) ? 2.0 : 5.5;
         for (int k = 0; k < N; k++) begin
            fill_drain(k);
            push(); pop();   // R9: step both pointers one position
         end
         fork
            begin repeat (150) push(); end
            begin repeat (150) pop(); end
         join
         chk(rseq == wseq, "R3 stream count", rseq, wseq);
      end

      // R10: reader drains full FIFO within about one write period
      rhalf = 0.25;
      repeat (4) @(negedge rd_clk);
      repeat (N) push();
      chk(wr_full == 1'b1, "R2 full before burst", int'(wr_full), 1);
      @(negedge rd_clk); rd_en = 1'b1;
      for (int i = 0; i < N; i++) begin
         @(negedge rd_clk);
         chk(rd_data == pat(rseq), "R10 burst data", int'(rd_data), int'(pat(rseq)));
         last_rd = rd_data; rseq++;
      end
      rd_en = 1'b0;
      chk(rd_empty == 1'b1, "R7 empty after burst", int'(rd_empty), 1);
      wait_full_clear("R10 full release");
      for (int i = 0; i < N; i++) begin
         @(negedge wr_clk);
         chk(wr_full == 1'b0, "R10 room after drain", int'(wr_full), 0);
         wr_data = pat(wseq); wr_en = 1'b1; wseq++;
         @(negedge wr_clk);
         wr_en = 1'b0;
      end
      chk(wr_full == 1'b1, "R10 full again", int'(wr_full), 1);
      repeat (N) pop();
      chk(rd_empty == 1'b1, "R7 final empty", int'(rd_empty), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule